// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

This block divides a base time reference into one of thirteen binary rates. It produces a square-wave pin and a one-cycle periodic event pulse, which is meant to set an interrupt flag elsewhere. The block runs on the system clock. A strobe input, `half_stb`, marks each half-period of the 32768 Hz base, so it nominally arrives 65536 times per second. A 16-bit divider counts these strobes, and a 4-bit rate code picks one divider bit as the output tap. With code c in 3..15, the selected rate repeats every 2^c strobes, which is 8192 Hz for code 3 and 2 Hz for code 15. Codes 1 and 2 are aliases of codes 8 and 9. Code 0 turns the divided output off.

A small mode machine chooses what drives the pin and the event pulse:
- `MODE_OFF`: the rate code is zero and there is no override. The pin is low and no events occur.
- `MODE_DIV`: a divided rate drives the pin and the events.
- `MODE_FULL`: the full-rate override is set. The pin follows the base clock (divider bit 0) and events are suppressed.

The next-state logic moves between these modes as follows:
- From `MODE_OFF` or `MODE_DIV`, setting the override leads to `MODE_FULL`.
- `MODE_OFF` goes to `MODE_DIV` when the code becomes non-zero. `MODE_DIV` goes to `MODE_OFF` when the code becomes zero.
- `MODE_FULL` goes back to `MODE_OFF` or `MODE_DIV` when the override is released, depending on the code.

The mode register follows the inputs one cycle late. A change of mode therefore shows at the outputs two cycles after the input changes.

Top module: `rate_wave_gen`

## Requirements
- R1: The divider advances only on cycles with `half_stb` high. While strobes are absent, the pin does not change and no event pulse occurs.
- R2: For rate code c in 3..15, with no override, event pulses are spaced exactly 2^c strobes apart.
- R3: Rate code 1 gives the same spacing as code 8 (256 strobes), and code 2 gives the same spacing as code 9 (512 strobes).
- R4: With rate code 0 and no override, `per_pulse` stays low and `sqw_out` is held low.
- R5: With `full_ovr` set, `sqw_out` toggles on every strobe, which is the 32768 Hz base, whatever the rate code and `sqw_en`.
- R6: With `full_ovr` set, no event pulse is produced.
- R7: With `full_ovr` clear and `sqw_en` low, `sqw_out` is held low, while event pulses continue at the selected rate.
- R8: In divided mode with `sqw_en` high, `sqw_out` is high for exactly half of each period (2^(c-1) strobes).
- R9: `per_pulse` is high for one cycle per period. It is asserted in the same cycle in which `sqw_out` rises.
- R10: `sqw_out` changes only on strobe-driven edges. After a rate-code change or an override change, no high or low run is shorter than the strobe spacing, which is half a base period.
- R11: During reset, `sqw_out` and `per_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_stb | input | 1 | One-cycle strobe per half-period of the 32768 Hz base |
| rate_code | input | CODE_W (4) | Rate select; 0 = off, 1/2 = aliases, 3..15 = divided rates |
| sqw_en | input | 1 | Enables the divided square wave on the pin |
| full_ovr | input | 1 | Forces the base clock onto the pin and suppresses events |
| sqw_out | output | 1 | Square-wave pin |
| per_pulse | output | 1 | One-cycle periodic event pulse |

## Verification
The following properties are checked on every cycle:
- With the override held, no event pulse occurs.
- With code 0, or with the enable low, the pin stays low.
- An event pulse never lasts more than one cycle.
- The pin only rises, and pulses only start, in the cycle after a strobe.

Exact period lengths, duty cycle and the alias mapping are frequency properties that only the bench can show. The bench sweeps every rate code and counts strobes between pulses and high cycles of the pin. It also shows run-length bounds across rate changes, under sparse strobes.

// File: rtl/rate_pkg.sv
package rate_pkg;

    // Operating mode of the output stage.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DIV  = 2'd1,
        MODE_FULL = 2'd2
    } wave_mode_e;

    // Lowest code that selects a divider tap directly.
    localparam int unsigned RATE_FIRST = 3;
    // Codes 1 and 2 are shifted up onto codes 8 and 9.
    localparam int unsigned ALIAS_SHIFT = 7;

    // Maps a raw rate code onto the code whose tap it uses.
    function automatic int unsigned eff_rate(input int unsigned code);
        if (code != 0 && code < RATE_FIRST) begin
            return code + ALIAS_SHIFT;
        end
        return code;
    endfunction

endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_stb,
    output logic [CNT_W-1:0] rise_v,
    output logic [CNT_W-1:0] fall_v
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + CNT_W'(1);

    // Free-running divider, advanced once per strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (half_stb) begin
            cnt_q <= cnt_nx;
        end
    end

    // Per-bit edge flags for the increment about to happen.
    assign rise_v = half_stb ? (~cnt_q &  cnt_nx) : '0;
    assign fall_v = half_stb ? ( cnt_q & ~cnt_nx) : '0;

endmodule

// File: rtl/rate_tap_decode.sv
module rate_tap_decode #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic [CODE_W-1:0] rate_code,
    output logic [CNT_W-1:0]  tap_oh,
    output logic              code_off
);
    import rate_pkg::*;

    int unsigned eff;

    always_comb begin
        eff = eff_rate(32'(rate_code));
    end

    // 1-of-N decode: effective code k selects divider bit k-1.
    for (genvar g = 0; g < CNT_W; g++) begin : g_tap
        assign tap_oh[g] = (eff >= RATE_FIRST) && (eff == 32'(g + 1));
    end

    assign code_off = (rate_code == '0);

endmodule

// File: rtl/rate_wave_fsm.sv
module rate_wave_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic code_off,
    input  logic full_ovr,
    input  logic sqw_en,
    input  logic sel_rise,
    input  logic sel_fall,
    input  logic base_rise,
    input  logic base_fall,
    output logic sqw_out,
    output logic per_pulse
);
    import rate_pkg::*;

    wave_mode_e mode_q;
    wave_mode_e mode_d;

    // Next-mode selection.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_OFF: begin
                if (full_ovr) begin
                    mode_d = MODE_FULL;
                end else if (!code_off) begin
                    mode_d = MODE_DIV;
                end
            end
            MODE_DIV: begin
                if (full_ovr) begin
                    mode_d = MODE_FULL;
                end else if (code_off) begin
                    mode_d = MODE_OFF;
                end
            end
            MODE_FULL: begin
                if (!full_ovr) begin
                    mode_d = code_off ? MODE_OFF : MODE_DIV;
                end
            end
            default: mode_d = MODE_OFF;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Output register: the pin moves only on tap edges, so no short runs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sqw_out   <= 1'b0;
            per_pulse <= 1'b0;
        end else begin
            per_pulse <= 1'b0;
            unique case (mode_q)
                MODE_OFF: begin
                    sqw_out <= 1'b0;
                end
                MODE_DIV: begin
                    per_pulse <= sel_rise;
                    if (!sqw_en) begin
                        sqw_out <= 1'b0;
                    end else if (sel_rise) begin
                        sqw_out <= 1'b1;
                    end else if (sel_fall) begin
                        sqw_out <= 1'b0;
                    end
                end
                MODE_FULL: begin
                    if (base_rise) begin
                        sqw_out <= 1'b1;
                    end else if (base_fall) begin
                        sqw_out <= 1'b0;
                    end
                end
                default: begin
                    sqw_out <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rate_wave_gen.sv
module rate_wave_gen #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_stb,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              sqw_en,
    input  logic              full_ovr,
    output logic              sqw_out,
    output logic              per_pulse
);

    localparam int CNT_W = 1 << CODE_W;

    logic [CNT_W-1:0] rise_v;
    logic [CNT_W-1:0] fall_v;
    logic [CNT_W-1:0] tap_oh;
    logic             code_off;
    logic             sel_rise;
    logic             sel_fall;

    rate_prescaler #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_stb (half_stb),
        .rise_v   (rise_v),
        .fall_v   (fall_v)
    );

    rate_tap_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .rate_code (rate_code),
        .tap_oh    (tap_oh),
        .code_off  (code_off)
    );

    assign sel_rise = |(rise_v & tap_oh);
    assign sel_fall = |(fall_v & tap_oh);

    rate_wave_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_off  (code_off),
        .full_ovr  (full_ovr),
        .sqw_en    (sqw_en),
        .sel_rise  (sel_rise),
        .sel_fall  (sel_fall),
        .base_rise (rise_v[0]),
        .base_fall (fall_v[0]),
        .sqw_out   (sqw_out),
        .per_pulse (per_pulse)
    );

endmodule

// File: rtl/rate_wave_gen_chk.sv
module rate_wave_gen_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_stb,
    input logic [CODE_W-1:0] rate_code,
    input logic              sqw_en,
    input logic              full_ovr,
    input logic              sqw_out,
    input logic              per_pulse
);

    // R6
    ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_ovr && $past(full_ovr) && $past(full_ovr, 2)) |-> !per_pulse);

    // R4
    code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0 && $past(rate_code) == '0 && $past(rate_code, 2) == '0 &&
         !full_ovr && !$past(full_ovr) && !$past(full_ovr, 2))
        |-> (!per_pulse && !sqw_out));

    // R7
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw_en && !$past(sqw_en) && !$past(sqw_en, 2) &&
         !full_ovr && !$past(full_ovr) && !$past(full_ovr, 2)) |-> !sqw_out);

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |=> !per_pulse);

    // R10
    pin_rise_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sqw_out) |-> $past(half_stb));

    // R1
    pulse_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_pulse) |-> $past(half_stb));

    // R11
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!sqw_out && !per_pulse));

endmodule

bind rate_wave_gen rate_wave_gen_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_stb  (half_stb),
    .rate_code (rate_code),
    .sqw_en    (sqw_en),
    .full_ovr  (full_ovr),
    .sqw_out   (sqw_out),
    .per_pulse (per_pulse)
);

// File: tb/test_rate_wave_gen.sv
module test_rate_wave_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_stb = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       sqw_en = 1'b0;
    logic       full_ovr = 1'b0;
    logic       sqw_out;
    logic       per_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rate_wave_gen i_rate_wave_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_stb  (half_stb),
        .rate_code (rate_code),
        .sqw_en    (sqw_en),
        .full_ovr  (full_ovr),
        .sqw_out   (sqw_out),
        .per_pulse (per_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Pulse spacing and duty for one rate code (R2, R3, R8, R9).
    task automatic measure(input int c);
        int    eff;
        int    n;
        int    hi;
        int    guard;
        logic  prev;
        string req;
        eff = (c == 1) ? 8 : (c == 2) ? 9 : c;
        req = (c < 3) ? "R3" : "R2";
        rate_code = 4'(c);
        repeat (3) @(negedge clk);
        guard = 0;
        while (per_pulse !== 1'b1 && guard < 70000) begin
            @(negedge clk);
            guard++;
        end
        n = 0;
        hi = 0;
        prev = sqw_out;
        do begin
            prev = sqw_out;
            @(negedge clk);
            n++;
            hi += int'(sqw_out);
        end while (per_pulse !== 1'b1 && n < 70000);
        chk($sformatf("%s spacing code %0d", req, c), n, 1 << eff);
        chk($sformatf("R8 high time code %0d", c), hi, 1 << (eff - 1));
        chk($sformatf("R9 pin rises with pulse code %0d", c), int'(sqw_out), 1);
        chk($sformatf("R9 pin low before pulse code %0d", c), int'(prev), 0);
        @(negedge clk);
        chk($sformatf("R9 single-cycle pulse code %0d", c), int'(per_pulse), 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual 195000 cycles expected fewer");
        wrap_up();
    end

    initial begin
        int   pulses;
        int   highs;
        int   changes;
        int   run;
        int   min_run;
        bit   seen;
        logic prev;

        repeat (3) @(negedge clk);
        chk("R11 pin in reset", int'(sqw_out), 0);
        chk("R11 pulse in reset", int'(per_pulse), 0);

        rst_n = 1'b1;
        half_stb = 1'b1;
        sqw_en = 1'b1;

        for (int c = 1; c < 16; c++) begin
            measure(c);
        end

        // R4: code zero
        rate_code = 4'd0;
        repeat (3) @(negedge clk);
        pulses = 0;
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            pulses += int'(per_pulse);
            highs += int'(sqw_out);
        end
        chk("R4 no pulses at code 0", pulses, 0);
        chk("R4 pin low at code 0", highs, 0);

        // R5 and R6: override
        full_ovr = 1'b1;
        rate_code = 4'd5;
        sqw_en = 1'b0;
        repeat (3) @(negedge clk);
        pulses = 0;
        changes = 0;
        prev = sqw_out;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            pulses += int'(per_pulse);
            if (sqw_out !== prev) changes++;
            prev = sqw_out;
        end
        chk("R5 pin toggles each strobe", changes, 64);
        chk("R6 no pulses under override", pulses, 0);

        // R7: enable low, events continue
        full_ovr = 1'b0;
        rate_code = 4'd3;
        repeat (3) @(negedge clk);
        pulses = 0;
        highs = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            pulses += int'(per_pulse);
            highs += int'(sqw_out);
        end
        chk("R7 pin held low", highs, 0);
        chk("R7 pulses continue", pulses, 20);

        // R1: strobes absent
        sqw_en = 1'b1;
        repeat (20) @(negedge clk);
        half_stb = 1'b0;
        repeat (3) @(negedge clk);
        pulses = 0;
        changes = 0;
        prev = sqw_out;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            pulses += int'(per_pulse);
            if (sqw_out !== prev) changes++;
            prev = sqw_out;
        end
        chk("R1 pin frozen without strobes", changes, 0);
        chk("R1 no pulses without strobes", pulses, 0);
        half_stb = 1'b1;
        repeat (3) @(negedge clk);
        pulses = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            pulses += int'(per_pulse);
        end
        chk("R1 pulses resume with strobes", pulses, 10);

        // R10: sparse strobes with rate and override changes
        min_run = 1000000;
        run = 0;
        seen = 1'b0;
        changes = 0;
        prev = sqw_out;
        for (int seg = 0; seg < 7; seg++) begin
            case (seg)
                0: rate_code = 4'd3;
                1: rate_code = 4'd4;
                2: rate_code = 4'd3;
                3: full_ovr = 1'b1;
                4: begin full_ovr = 1'b0; rate_code = 4'd6; end
                5: rate_code = 4'd5;
                default: rate_code = 4'd3;
            endcase
            for (int i = 0; i < 150; i++) begin
                @(negedge clk);
                run++;
                if (sqw_out !== prev) begin
                    changes++;
                    if (seen && run < min_run) min_run = run;
                    seen = 1'b1;
                    run = 0;
                end
                prev = sqw_out;
                half_stb = (i % 3 == 2);
            end
        end
        chk("R10 shortest pin run at least strobe spacing", (min_run >= 3) ? 1 : 0, 1);
        chk("R10 pin kept switching", (changes > 20) ? 1 : 0, 1);

        wrap_up();
    end

endmodule